// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period register and a 10-bit duty setting. An internal divider (ratio 1, 4 or 16 times a fixed factor of four) drives an 8-bit timer. Two fine bits taken from inside that divider extend the timer to a 10-bit count. That count is compared with the duty value, so an 8-bit period still gives up to 10 bits of duty resolution.

Software loads the period, the duty and the divider ratio through a small write port. It may write them whenever it likes. The duty is held in a buffer register and copied into an active copy only when the timer reaches the period value and rolls over. A duty change therefore never cuts a period short or stretches it. The active copy can be read on a dedicated output. A one-cycle pulse marks the first clock of every period.

Top module: `pwm10_gen`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` in the register named by `wr_addr`. Address 0 is the period P (8 bits). Address 1 is duty bits [9:2]. Address 2 is duty bits [1:0], taken from `wr_data[1:0]`. Address 3 is the ratio select S, taken from `wr_data[1:0]`. After the next rollover, `duty_active` shows the full 10-bit duty that was written.
- R2: `duty_active` changes only at a rollover. A duty written in the middle of a period does not change that period's output and takes effect in the following period.
- R3: The divide ratio N is 1 for S=0, 4 for S=1 and 16 for S=2 or S=3. A period lasts (P+1)*4*N clock cycles.
- R4: In every period the output is high for the first D*N cycles, where D is the active duty. It goes low when the 10-bit count {timer, fine bits} equals D.
- R5: A duty of 0 keeps the output low for the whole period.
- R6: A duty of 4*(P+1) or more keeps the output high for the whole period.
- R7: `period_tick` is high for exactly one cycle, the first cycle of each period. In that cycle `pwm_out` is high exactly when `duty_active` is nonzero. The output rises only in such a cycle.
- R8: While `en` is low, `pwm_out` and `period_tick` are 0 and the timer and divider are cleared. The stored registers and `duty_active` keep their values. The partial period that follows re-enabling keeps the output low until the first rollover.
- R9: After reset, `pwm_out`, `period_tick` and `duty_active` are 0. The period register is 0xFF, the duty is 0 and the ratio is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low clears the timer and the output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty high, 2 duty low, 3 ratio |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| period_tick | output | 1 | One-cycle pulse in the first cycle of each period |
| duty_active | output | 10 | Duty value in use for the current period |

## Verification
A register write is stored at the clock edge that follows the strobe. It has no visible effect until the next rollover, which clears the timer, raises `period_tick` and loads `duty_active` at the same edge. From then on, the high time and the length of the period count whole clock cycles. The bench samples on the falling edge. It measures each period from one `period_tick` to the next and counts the high cycles in between. It reads `duty_active` in the tick cycle, or partway through a period when checking that a mid-period write has not yet taken effect. It therefore never depends on the exact edge where a single comparison fires.

// File: rtl/pwm10_pkg.sv
// Package: shared constants and encodings for the 10-bit PWM generator.
// Assumes the fine-bit width is fixed at 2 and the largest ratio is 16.
package pwm10_pkg;
    localparam int FINE_W    = 2;            // fine bits appended to the timer
    localparam int PSC_LOG   = 4;            // log2 of the largest ratio (16)
    localparam int DIV_W     = FINE_W + PSC_LOG;

    typedef enum logic [1:0] {
        ADDR_PERIOD  = 2'd0,
        ADDR_DUTY_HI = 2'd1,
        ADDR_DUTY_LO = 2'd2,
        ADDR_RATIO   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        RATIO_1   = 2'd0,
        RATIO_4   = 2'd1,
        RATIO_16  = 2'd2,
        RATIO_16B = 2'd3
    } ratio_e;
endpackage

// File: rtl/pwm10_regs.sv
// Module: software-visible setting registers (period, buffered duty, ratio).
// Assumes single-cycle writes; each write lands on the next clock edge.
module pwm10_regs
    import pwm10_pkg::*;
#(
    parameter int PER_W = 8,
    localparam int DUTY_W = PER_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [PER_W-1:0]  wr_data,
    output logic [PER_W-1:0]  period_q,
    output logic [DUTY_W-1:0] duty_buf,
    output ratio_e            ratio_q
);
    logic [PER_W-1:0]  duty_hi_q;
    logic [FINE_W-1:0] duty_lo_q;

    // Store the addressed field on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q  <= '1;
            duty_hi_q <= '0;
            duty_lo_q <= '0;
            ratio_q   <= RATIO_1;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_PERIOD:  period_q  <= wr_data;
                ADDR_DUTY_HI: duty_hi_q <= wr_data;
                ADDR_DUTY_LO: duty_lo_q <= wr_data[FINE_W-1:0];
                ADDR_RATIO:   ratio_q   <= ratio_e'(wr_data[1:0]);
                default:      ;
            endcase
        end
    end

    // Join the two duty fields into the buffered 10-bit value.
    always_comb duty_buf = {duty_hi_q, duty_lo_q};
endmodule

// File: rtl/pwm10_timebase.sv
// Module: divider, timer and fine bits. Produces the extended count and
// the rollover event (timer equals period at the end of a timer step).
// Assumes the ratio may change at any time; a divider value that is over
// the new limit wraps at once.
module pwm10_timebase
    import pwm10_pkg::*;
#(
    parameter int PER_W = 8,
    localparam int DUTY_W = PER_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PER_W-1:0]  period_q,
    input  ratio_e            ratio_q,
    output logic [DUTY_W-1:0] count,
    output logic              rollover
);
    localparam logic [DIV_W-1:0] LIM_1  = DIV_W'((1 << FINE_W) - 1);
    localparam logic [DIV_W-1:0] LIM_4  = DIV_W'((1 << (FINE_W + 2)) - 1);
    localparam logic [DIV_W-1:0] LIM_16 = DIV_W'((1 << DIV_W) - 1);

    logic [DIV_W-1:0]  div_q;
    logic [PER_W-1:0]  tmr_q;
    logic [DIV_W-1:0]  div_lim;
    logic [FINE_W-1:0] fine;
    logic              step_end;

    // Pick the divider limit and the fine-bit slice for the ratio.
    always_comb begin
        case (ratio_q)
            RATIO_1: begin
                div_lim = LIM_1;
                fine    = div_q[FINE_W-1:0];
            end
            RATIO_4: begin
                div_lim = LIM_4;
                fine    = div_q[FINE_W+1:2];
            end
            default: begin
                div_lim = LIM_16;
                fine    = div_q[FINE_W+3:4];
            end
        endcase
    end

    // Mark the last clock of a timer step and of a period.
    always_comb begin
        step_end = (div_q >= div_lim);
        rollover = en && step_end && (tmr_q == period_q);
        count    = {tmr_q, fine};
    end

    // Advance the divider every clock and the timer at each step end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_q <= '0;
            tmr_q <= '0;
        end else if (step_end) begin
            div_q <= '0;
            tmr_q <= rollover ? '0 : tmr_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm10_compare.sv
// Module: active duty copy, output flag and period pulse.
// Assumes the count is 0 in the cycle after a rollover; the output is
// cleared from the first cycle in which the count equals the active duty.
module pwm10_compare
    import pwm10_pkg::*;
#(
    parameter int PER_W = 8,
    localparam int DUTY_W = PER_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rollover,
    input  logic [DUTY_W-1:0] count,
    input  logic [DUTY_W-1:0] duty_buf,
    output logic              pwm_out,
    output logic              period_tick,
    output logic [DUTY_W-1:0] duty_active
);
    logic high_q;
    logic tick_q;
    logic eq_now;

    // Detect the clear point for the current period.
    always_comb eq_now = (count == duty_active);

    // Load the active duty at rollover and track the output flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_active <= '0;
            high_q      <= 1'b0;
            tick_q      <= 1'b0;
        end else if (!en) begin
            high_q <= 1'b0;
            tick_q <= 1'b0;
        end else if (rollover) begin
            duty_active <= duty_buf;
            high_q      <= (duty_buf != '0);
            tick_q      <= 1'b1;
        end else begin
            tick_q <= 1'b0;
            if (eq_now) high_q <= 1'b0;
        end
    end

    // Drive the output from registered state only.
    always_comb begin
        pwm_out     = high_q & ~eq_now;
        period_tick = tick_q;
    end
endmodule

// File: rtl/pwm10_gen.sv
// Module: top of the double-buffered 10-bit PWM generator.
// Assumes one write port shared by all settings; output is one pin.
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int PER_W = 8,
    localparam int DUTY_W = PER_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [PER_W-1:0]  wr_data,
    output logic              pwm_out,
    output logic              period_tick,
    output logic [DUTY_W-1:0] duty_active
);
    logic [PER_W-1:0]  period_q;
    logic [DUTY_W-1:0] duty_buf;
    ratio_e            ratio_q;
    logic [DUTY_W-1:0] count;
    logic              rollover;

    pwm10_regs #(.PER_W(PER_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .period_q (period_q),
        .duty_buf (duty_buf),
        .ratio_q  (ratio_q)
    );

    pwm10_timebase #(.PER_W(PER_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .period_q (period_q),
        .ratio_q  (ratio_q),
        .count    (count),
        .rollover (rollover)
    );

    pwm10_compare #(.PER_W(PER_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .rollover    (rollover),
        .count       (count),
        .duty_buf    (duty_buf),
        .pwm_out     (pwm_out),
        .period_tick (period_tick),
        .duty_active (duty_active)
    );
endmodule

// File: rtl/pwm10_gen_chk.sv
// Module: property checker bound to pwm10_gen; observes ports only.
module pwm10_gen_chk #(
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              pwm_out,
    input logic              period_tick,
    input logic [DUTY_W-1:0] duty_active
);
    // R7: the period pulse lasts one cycle
    a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |=> !period_tick);

    // R7: output state in the first cycle matches the active duty
    a_r7_start_level: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |-> (pwm_out == (duty_active != '0)));

    // R7: the output only rises at the start of a period
    a_r7_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> period_tick);

    // R2: the active duty is constant away from a rollover
    a_r2_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
        !period_tick |-> $stable(duty_active));

    // R8: disabled block drives no output and no pulse
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_out && !period_tick));

    // R5: zero duty never drives the output high
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_active == '0) |-> !pwm_out);
endmodule

bind pwm10_gen pwm10_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .pwm_out     (pwm_out),
    .period_tick (period_tick),
    .duty_active (duty_active)
);

// File: tb/sim_pwm10_gen.sv
module sim_pwm10_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out;
    logic       period_tick;
    logic [9:0] duty_active;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm10_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
        .period_tick(period_tick), .duty_active(duty_active)
    );

    typedef struct packed {
        logic [7:0]  per;
        logic [9:0]  duty;
        logic [1:0]  sel;
        logic [15:0] len;
        logic [15:0] hi;
    } vec_t;

    // period, duty, ratio select, expected period length, expected high cycles
    localparam vec_t VEC [9] = '{
        '{8'd7,   10'd10,   2'd0, 16'd32,   16'd10},    // R4
        '{8'd7,   10'd0,    2'd0, 16'd32,   16'd0},     // R5
        '{8'd3,   10'd5,    2'd1, 16'd64,   16'd20},    // R3 ratio 4
        '{8'd1,   10'd3,    2'd2, 16'd128,  16'd48},    // R3 ratio 16
        '{8'd31,  10'd200,  2'd0, 16'd128,  16'd128},   // R6
        '{8'd31,  10'd127,  2'd0, 16'd128,  16'd127},   // R4 7-bit top
        '{8'd255, 10'd1023, 2'd0, 16'd1024, 16'd1023},  // R4 10-bit top
        '{8'd0,   10'd2,    2'd0, 16'd4,    16'd2},     // R3 shortest
        '{8'd2,   10'd12,   2'd3, 16'd192,  16'd192}    // R6 edge, select 3
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_duty(input logic [9:0] d);
        wr(2'd1, d[9:2]);
        wr(2'd2, {6'd0, d[1:0]});
    endtask

    // Measure one period from a tick to the next; optional mid-period duty write.
    task automatic measure(input bit mid, input logic [9:0] nd, input int keep,
                           output int len, output int hi, output int first);
        while (!period_tick) @(negedge clk);
        first = int'(pwm_out);
        len = 0; hi = 0;
        do begin
            if (mid && len == 3) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = nd[9:2]; end
            if (mid && len == 4) begin wr_addr = 2'd2; wr_data = {6'd0, nd[1:0]}; end
            if (mid && len == 5) wr_en = 1'b0;
            if (mid && len == 8) chk("R2 active duty held mid-period", int'(duty_active), keep);
            hi += int'(pwm_out);
            len++;
            @(negedge clk);
        end while (!period_tick);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int len, hi, first, pre;
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        chk("R9 pwm_out in reset", int'(pwm_out), 0);
        chk("R9 period_tick in reset", int'(period_tick), 0);
        chk("R9 duty_active in reset", int'(duty_active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: default period 0xFF and ratio 1 -> 1024-cycle period
        set_duty(10'd100);
        en = 1'b1;
        measure(0, 10'd0, 0, len, hi, first);
        chk("R9 default period length", len, 1024);
        chk("R9 default high cycles", hi, 100);

        // Table walk
        for (int i = 0; i < 9; i++) begin
            en = 1'b0;
            @(negedge clk);
            wr(2'd0, VEC[i].per);
            wr(2'd3, {6'd0, VEC[i].sel});
            set_duty(VEC[i].duty);
            en = 1'b1;
            pre = 0;
            @(negedge clk);
            while (!period_tick) begin pre += int'(pwm_out); @(negedge clk); end
            chk("R8 low before first rollover", pre, 0);
            measure(0, 10'd0, 0, len, hi, first);
            chk("R3 period length", len, int'(VEC[i].len));
            chk("R4/R5/R6 high cycles", hi, int'(VEC[i].hi));
            chk("R1 duty_active readback", int'(duty_active), int'(VEC[i].duty));
            chk("R7 level at period start", first, (VEC[i].duty != 0) ? 1 : 0);
        end

        // R2: mid-period write is deferred by one period
        en = 1'b0;
        @(negedge clk);
        wr(2'd0, 8'd7);
        wr(2'd3, 8'd0);
        set_duty(10'd10);
        en = 1'b1;
        measure(0, 10'd0, 0, len, hi, first);
        measure(1, 10'd20, 10, len, hi, first);
        chk("R2 current period keeps old duty", hi, 10);
        measure(0, 10'd0, 0, len, hi, first);
        chk("R2 next period uses new duty", hi, 20);
        chk("R2 duty_active updated", int'(duty_active), 20);

        // R8: disable holds outputs low and keeps registers
        en = 1'b0;
        pre = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            pre += int'(pwm_out) + int'(period_tick);
        end
        chk("R8 outputs quiet while disabled", pre, 0);
        chk("R8 duty_active kept while disabled", int'(duty_active), 20);
        en = 1'b1;
        measure(0, 10'd0, 0, len, hi, first);
        measure(0, 10'd0, 0, len, hi, first);
        chk("R8 settings kept after re-enable: length", len, 32);
        chk("R8 settings kept after re-enable: high", hi, 20);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule